// File: doc/BRIEF.md
# Bus Cycle Termination Resolver

This block is the master-side logic that decides how an external bus cycle ends. A caller starts a cycle with an address, a transfer size and a direction. The block then drives those onto the bus and watches three active-low termination inputs: acknowledge, bus error and halt. The first clock on which acknowledge or bus error is seen low is the first sample point, N. The inputs are sampled again two clocks later, at N+2. The two samples together decide the outcome. A bus error or halt that arrives late can still change a cycle that was already acknowledged.

There are four outcomes. Each is reported as a one-clock pulse on its own output: plain completion, completion followed by a halt, a bus-error exception, or a retry. After a halted completion or a retry, the block stays in a halt wait until halt is sampled negated. On a retry it then re-runs the same cycle, with the same address, size and direction.

Top module: `bus_term_resolver`

## Requirements
- R1: While reset is high and in the clock after it, busy, busActive, haltWait and all four result outputs are 0. Reset is synchronous.
- R2: When start is 1 and the block is idle, reqAddr, reqSize and reqWrite are captured. They appear on busAddr, busSize and busWrite with busActive=1 from the next clock. A start while busy is ignored, and the bus fields stay unchanged.
- R3: While waiting, the inputs are examined on every clock. The first clock with ackN=0 or berrN=0 is point N, and a low haltN alone does not end the wait. The clock after N is not sampled. The second sample is taken two clocks after N, and the result pulse appears in the clock after that sample.
- R4: If acknowledge is low at N, and bus error and halt are high at both N and N+2, then done pulses and the block returns to idle.
- R5: If acknowledge is low at N, halt is low at N or at N+2, and bus error is high at both samples, then haltedDone pulses. haltWait then stays 1 until haltN is sampled 1, after which the block is idle.
- R6: If bus error is low at N and halt is high at both samples, berrExc pulses, whether or not acknowledge was also low. Bus error takes precedence over acknowledge.
- R7: If acknowledge is low at N and bus error first goes low at N+2 with halt high at both samples, berrExc pulses.
- R8: If bus error is low at either sample and halt is low at either sample, retry pulses and haltWait follows. Once haltN is sampled 1, the block drives busActive again with the same address, size and direction, and resolves the repeated cycle afresh.
- R9: Each resolved cycle produces exactly one of done, haltedDone, berrExc and retry, for exactly one clock.
- R10: A reset raised in the middle of a cycle returns the block to idle with busActive and every result output at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a bus cycle (taken only when idle) |
| reqAddr | input | ADDR_W | Cycle address |
| reqSize | input | SIZE_W | Transfer size code |
| reqWrite | input | 1 | 1 for a write, 0 for a read |
| ackN | input | 1 | Data acknowledge, active low |
| berrN | input | 1 | Bus error, active low |
| haltN | input | 1 | Halt, active low |
| busAddr | output | ADDR_W | Address driven for the cycle |
| busSize | output | SIZE_W | Size driven for the cycle |
| busWrite | output | 1 | Direction driven for the cycle |
| busActive | output | 1 | Cycle in progress on the bus |
| busy | output | 1 | Block not idle |
| done | output | 1 | Pulse: normal completion |
| haltedDone | output | 1 | Pulse: completion followed by halt wait |
| berrExc | output | 1 | Pulse: bus-error exception |
| retry | output | 1 | Pulse: cycle will be re-run |
| haltWait | output | 1 | Waiting for halt to be negated |

## Verification
The hardest situation to reach from the ports is a late change of outcome. In that case a cycle has already been acknowledged at N, and bus error, or bus error with halt, appears only at N+2. The bench gets there by driving the inputs on falling edges with exact clock counting. It places acknowledge on the clock that becomes N, puts a misleading bus error on the unsampled clock in between, and then drives the decisive values exactly two clocks after N. The retry path is then followed through a held halt and into the re-issued cycle, whose bus fields are compared with the original request.

// File: rtl/termres_pkg.sv
package termres_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAITN,
    ST_SPACE,
    ST_SAMP2,
    ST_HOLD
  } ctrlState_t;

  typedef enum logic [1:0] {
    OUT_DONE,
    OUT_HALTED,
    OUT_BERR,
    OUT_RETRY
  } outcome_t;

  typedef struct packed {
    logic loadReq;   // capture request fields
    logic capFirst;  // capture first sample (point N)
  } dpStrobe_t;

  // Combine the stored first sample with the live second sample.
  function automatic outcome_t classify(input logic berrSeen, input logic haltSeen);
    if (berrSeen && haltSeen) return OUT_RETRY;
    if (berrSeen)             return OUT_BERR;
    if (haltSeen)             return OUT_HALTED;
    return OUT_DONE;
  endfunction

endpackage

// File: rtl/termres_datapath.sv
module termres_datapath
  import termres_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [SIZE_W-1:0] reqSize,
  input  logic              reqWrite,
  input  logic              ackN,
  input  logic              berrN,
  input  logic              haltN,
  output logic [ADDR_W-1:0] busAddr,
  output logic [SIZE_W-1:0] busSize,
  output logic              busWrite,
  output logic              firstHit,
  output logic              haltNegated,
  output outcome_t          outcome
);

  logic ackNow, berrNow, haltNow;
  logic firstBerr, firstHalt;
  logic [ADDR_W-1:0] addrQ;
  logic [SIZE_W-1:0] sizeQ;
  logic writeQ;

  assign ackNow  = ~ackN;
  assign berrNow = ~berrN;
  assign haltNow = ~haltN;

  // Request fields are held across retries; only a new start reloads them.
  always_ff @(posedge clk) begin
    if (rst) begin
      addrQ  <= '0;
      sizeQ  <= '0;
      writeQ <= 1'b0;
    end else if (strobe.loadReq) begin
      addrQ  <= reqAddr;
      sizeQ  <= reqSize;
      writeQ <= reqWrite;
    end
  end

  // First sample register (point N).
  always_ff @(posedge clk) begin
    if (rst || strobe.loadReq) begin
      firstBerr <= 1'b0;
      firstHalt <= 1'b0;
    end else if (strobe.capFirst) begin
      firstBerr <= berrNow;
      firstHalt <= haltNow;
    end
  end

  assign busAddr     = addrQ;
  assign busSize     = sizeQ;
  assign busWrite    = writeQ;
  assign firstHit    = ackNow | berrNow;
  assign haltNegated = haltN;
  assign outcome     = classify(firstBerr | berrNow, firstHalt | haltNow);

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    !strobe.loadReq |=> $stable(busAddr)); // R2

  AST_SIZE_HELD: assert property (@(posedge clk) disable iff (rst)
    !strobe.loadReq |=> ($stable(busSize) && $stable(busWrite))); // R8

endmodule

// File: rtl/termres_ctrl.sv
module termres_ctrl
  import termres_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      start,
  input  logic      firstHit,
  input  logic      haltNegated,
  input  outcome_t  outcome,
  output dpStrobe_t strobe,
  output logic      busActive,
  output logic      busy,
  output logic      haltWait,
  output logic      done,
  output logic      haltedDone,
  output logic      berrExc,
  output logic      retry
);

  ctrlState_t state, stateNext;
  logic retryPending, retryPendingNext;
  logic [3:0] resultNext;
  logic anyResult;

  always_comb begin
    stateNext        = state;
    retryPendingNext = retryPending;
    resultNext       = 4'b0000;
    strobe           = '0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strobe.loadReq   = 1'b1;
          retryPendingNext = 1'b0;
          stateNext        = ST_WAITN;
        end
      end
      ST_WAITN: begin
        if (firstHit) begin
          strobe.capFirst = 1'b1;
          stateNext       = ST_SPACE;
        end
      end
      ST_SPACE: stateNext = ST_SAMP2;
      ST_SAMP2: begin
        unique case (outcome)
          OUT_DONE:   begin resultNext = 4'b1000; stateNext = ST_IDLE; end
          OUT_HALTED: begin resultNext = 4'b0100; stateNext = ST_HOLD; end
          OUT_BERR:   begin resultNext = 4'b0010; stateNext = ST_IDLE; end
          OUT_RETRY:  begin resultNext = 4'b0001; stateNext = ST_HOLD; end
          default:    stateNext = ST_IDLE;
        endcase
        retryPendingNext = (outcome == OUT_RETRY);
      end
      ST_HOLD: begin
        if (haltNegated) begin
          stateNext        = retryPending ? ST_WAITN : ST_IDLE;
          retryPendingNext = 1'b0;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      retryPending <= 1'b0;
      {done, haltedDone, berrExc, retry} <= 4'b0000;
    end else begin
      state        <= stateNext;
      retryPending <= retryPendingNext;
      {done, haltedDone, berrExc, retry} <= resultNext;
    end
  end

  assign busActive = (state == ST_WAITN) || (state == ST_SPACE) || (state == ST_SAMP2);
  assign busy      = (state != ST_IDLE);
  assign haltWait  = (state == ST_HOLD);
  assign anyResult = done | haltedDone | berrExc | retry;

  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done, haltedDone, berrExc, retry})); // R9

  AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (rst)
    anyResult |=> !anyResult); // R9

  AST_WAIT_NO_RESULT: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAITN && !firstHit) |=> !anyResult); // R3

  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (haltWait && !haltNegated) |=> haltWait); // R5

  AST_RETRY_REISSUE: assert property (@(posedge clk) disable iff (rst)
    (haltWait && haltNegated && retryPending) |=> busActive); // R8

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    (done || berrExc) |-> !busy); // R4

endmodule

// File: rtl/bus_term_resolver.sv
module bus_term_resolver
  import termres_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [SIZE_W-1:0] reqSize,
  input  logic              reqWrite,
  input  logic              ackN,
  input  logic              berrN,
  input  logic              haltN,
  output logic [ADDR_W-1:0] busAddr,
  output logic [SIZE_W-1:0] busSize,
  output logic              busWrite,
  output logic              busActive,
  output logic              busy,
  output logic              done,
  output logic              haltedDone,
  output logic              berrExc,
  output logic              retry,
  output logic              haltWait
);

  dpStrobe_t strobe;
  logic firstHit, haltNegated;
  outcome_t outcome;

  termres_ctrl uCtrl (
    .clk(clk), .rst(rst), .start(start),
    .firstHit(firstHit), .haltNegated(haltNegated), .outcome(outcome),
    .strobe(strobe), .busActive(busActive), .busy(busy), .haltWait(haltWait),
    .done(done), .haltedDone(haltedDone), .berrExc(berrExc), .retry(retry)
  );

  termres_datapath #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) uDp (
    .clk(clk), .rst(rst), .strobe(strobe),
    .reqAddr(reqAddr), .reqSize(reqSize), .reqWrite(reqWrite),
    .ackN(ackN), .berrN(berrN), .haltN(haltN),
    .busAddr(busAddr), .busSize(busSize), .busWrite(busWrite),
    .firstHit(firstHit), .haltNegated(haltNegated), .outcome(outcome)
  );

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (!busy && !busActive && !haltWait)); // R10

endmodule

// File: tb/sim_bus_term_resolver.sv
module sim_bus_term_resolver;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [1:0] reqSize = '0;
  logic reqWrite = 1'b0;
  logic ackN = 1'b1, berrN = 1'b1, haltN = 1'b1;
  logic [31:0] busAddr;
  logic [1:0] busSize;
  logic busWrite, busActive, busy, done, haltedDone, berrExc, retry, haltWait;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  bus_term_resolver u0 (
    .clk(clk), .rst(rst), .start(start), .reqAddr(reqAddr), .reqSize(reqSize),
    .reqWrite(reqWrite), .ackN(ackN), .berrN(berrN), .haltN(haltN),
    .busAddr(busAddr), .busSize(busSize), .busWrite(busWrite),
    .busActive(busActive), .busy(busy), .done(done), .haltedDone(haltedDone),
    .berrExc(berrExc), .retry(retry), .haltWait(haltWait)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] results();
    return {done, haltedDone, berrExc, retry};
  endfunction

  // exp: 0 done, 1 haltedDone, 2 berrExc, 3 retry
  task automatic runCycle(input logic [31:0] a, input logic [1:0] sz, input logic wr,
                          input bit a1, input bit b1, input bit h1, input bit midBerr,
                          input bit a2, input bit b2, input bit h2,
                          input int exp, input string req);
    logic [3:0] expVec;
    expVec = 4'b1000 >> exp;
    @(negedge clk);
    start = 1'b1; reqAddr = a; reqSize = sz; reqWrite = wr;
    @(negedge clk);
    start = 1'b0;
    chk("R2", "busActive after start", busActive, 1);
    chk("R2", "bus fields", {busAddr, busSize, busWrite}, {a, sz, wr});
    ackN = ~a1; berrN = ~b1; haltN = ~h1;
    @(negedge clk);
    ackN = 1'b1; berrN = ~midBerr; haltN = ~h1;
    @(negedge clk);
    ackN = ~a2; berrN = ~b2; haltN = ~h2;
    @(negedge clk);
    chk(req, "result vector", results(), expVec);
    chk("R9", "one result", $countones(results()), 1);
    ackN = 1'b1; berrN = 1'b1;
    if (exp == 1 || exp == 3) begin
      haltN = 1'b0;
      chk(req, "haltWait entered", haltWait, 1);
      @(negedge clk);
      chk("R9", "pulse one clock", results(), 0);
      chk(req, "haltWait held", haltWait, 1);
      haltN = 1'b1;
      @(negedge clk);
      chk(req, "haltWait left", haltWait, 0);
      if (exp == 3) begin
        chk("R8", "reissue active", busActive, 1);
        chk("R8", "reissue fields", {busAddr, busSize, busWrite}, {a, sz, wr});
        ackN = 1'b0;
        @(negedge clk); ackN = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R8", "retried cycle done", results(), 4'b1000);
      end else begin
        chk("R5", "idle after halt", busy, 0);
      end
    end else begin
      haltN = 1'b1;
      chk(req, "idle after result", busy, 0);
      chk(req, "bus released", busActive, 0);
      @(negedge clk);
      chk("R9", "pulse one clock", results(), 0);
    end
  endtask

  task automatic tReset();
    @(negedge clk);
    chk("R1", "outputs in reset", {busy, busActive, haltWait, results()}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "outputs after reset", {busy, busActive, haltWait, results()}, 0);
  endtask

  task automatic tWaitHalt();
    @(negedge clk);
    start = 1'b1; reqAddr = 32'h0000_4444; reqSize = 2'd1; reqWrite = 1'b0;
    @(negedge clk);
    start = 1'b0; haltN = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R3", "halt alone keeps waiting", {busActive, results()}, 5'b10000);
    end
    haltN = 1'b1; ackN = 1'b0;
    @(negedge clk); ackN = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R3", "late ack resolves done", results(), 4'b1000);
  endtask

  task automatic tStartIgnored();
    @(negedge clk);
    start = 1'b1; reqAddr = 32'hAAAA_0001; reqSize = 2'd2; reqWrite = 1'b1;
    @(negedge clk);
    reqAddr = 32'h5555_0002; reqSize = 2'd0; reqWrite = 1'b0;
    @(negedge clk);
    start = 1'b0;
    chk("R2", "start ignored while busy", {busAddr, busSize, busWrite},
        {32'hAAAA_0001, 2'd2, 1'b1});
    ackN = 1'b0;
    @(negedge clk); ackN = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R2", "first cycle finishes", results(), 4'b1000);
  endtask

  task automatic tResetMid();
    @(negedge clk);
    start = 1'b1; reqAddr = 32'h1234_5678;
    @(negedge clk);
    start = 1'b0; ackN = 1'b0;
    @(negedge clk);
    ackN = 1'b1; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R10", "reset mid cycle", {busy, busActive, haltWait, results()}, 0);
    @(negedge clk);
    chk("R10", "stays idle", {busy, results()}, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    tReset();
    // a1 b1 h1 mid a2 b2 h2
    runCycle(32'h0000_1000, 2'd0, 1'b0, 1, 0, 0, 0, 0, 0, 0, 0, "R4");
    runCycle(32'h0000_1004, 2'd1, 1'b1, 1, 0, 0, 1, 0, 0, 0, 0, "R3");
    runCycle(32'h0000_2000, 2'd2, 1'b0, 1, 0, 0, 0, 0, 0, 1, 1, "R5");
    runCycle(32'h0000_2004, 2'd3, 1'b1, 1, 0, 1, 0, 0, 0, 0, 1, "R5");
    runCycle(32'h0000_3000, 2'd0, 1'b1, 1, 1, 0, 0, 0, 0, 0, 2, "R6");
    runCycle(32'h0000_3004, 2'd1, 1'b0, 0, 1, 0, 0, 0, 0, 0, 2, "R6");
    runCycle(32'h0000_3008, 2'd2, 1'b0, 1, 0, 0, 0, 0, 1, 0, 2, "R7");
    runCycle(32'h0000_4000, 2'd3, 1'b1, 0, 1, 1, 0, 0, 0, 1, 3, "R8");
    runCycle(32'h0000_4008, 2'd1, 1'b0, 1, 0, 0, 0, 0, 1, 1, 3, "R8");
    tWaitHalt();
    tStartIgnored();
    tResetMid();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule